// File: doc/BRIEF.md
# Shadow RAM with Nonvolatile Backup

This block is a small static memory of 256 words of 4 bits, paired word for word with a nonvolatile backing array of the same shape. A host reads and writes the RAM through an active-low select, an active-low write strobe, an 8-bit address and a 4-bit data path. The pad's three-state behaviour is split into a data input, a data output and an output enable.

Two active-low commands move the whole array at once. The save command copies the RAM into the backing array. The restore command copies the backing array into the RAM. A sequencer walks every address once per transfer and holds a busy flag for a fixed, parameterised number of clock cycles. Save and restore take priority over host access. Restore takes priority over save.

If a save command arrives while a host write is being applied, that write is cut off. The word is then flagged as invalid, and the flag follows the word through later saves and restores until the host writes the word again.

Top module: `nvsram_shadow`

## Requirements
- R1: After reset, busy and dout_en are 0, every RAM word reads 0, and rd_bad is 0.
- R2: With sel_n=0, wr_n=1, busy=0 and both commands high, dout_en is 1 and dout shows the word at addr in the same cycle. rd_bad is 1 only if that word is flagged invalid.
- R3: With sel_n=0, wr_n=0, busy=0 and both commands high at a rising clock edge, din is stored at addr and that word's invalid flag is cleared. dout_en is 0 while the write strobe is low.
- R4: dout_en is 0 whenever sel_n=1 or busy=1.
- R5: save_n=0 sampled while idle, with restore_n=1, raises busy at the next edge. Busy stays high for exactly STORE_CYCLES cycles, after which the backing array holds the RAM contents and flags. The level of save_n after the start has no effect.
- R6: While a save is running, wr_n and restore_n have no effect: the RAM is unchanged and the save runs its full length.
- R7: restore_n=0 sampled while idle raises busy for exactly RECALL_CYCLES cycles, after which every RAM word and flag equals the backing array.
- R8: restore_n=0 blocks a save from starting. If both commands are low on the same idle cycle, a restore of RECALL_CYCLES cycles runs.
- R9: A save that starts on an edge where a host write is applied discards the write and flags that word invalid. The flag is copied to the backing array, comes back with a restore, and is cleared by a later host write.
- R10: A command that goes low during a read drops dout_en in that same cycle.
- R11: While busy=1, a host write changes no RAM word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (high = read) |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data (0 when not driven) |
| dout_en | output | 1 | Output enable for the data pads |
| rd_bad | output | 1 | Addressed word is flagged invalid (valid with dout_en) |
| save_n | input | 1 | Active-low command: copy RAM to backing array |
| restore_n | input | 1 | Active-low command: copy backing array to RAM |
| busy | output | 1 | A transfer is in progress |

## Verification
The assertions check, on every cycle, the following:
- the output enable stays low while deselected or busy;
- no host write lands during a transfer;
- a started save keeps running whatever its inputs do;
- restore wins over save when both are low on an idle cycle;
- the transfer counter advances one address per cycle.

The bench scenarios cover what needs whole-array state:
- the exact busy length of each transfer kind;
- the RAM and backing contents after save and restore;
- the ignored write and restore during a save;
- the invalid-word flag following an aborted write through a save, a rewrite and a restore.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_STORE  = 2'd1,
    XF_RECALL = 2'd2
  } xfer_e;

  // index of the final cycle of a transfer of the given kind
  function automatic int unsigned span_last(xfer_e m, int unsigned store_cyc,
                                            int unsigned recall_cyc);
    case (m)
      XF_STORE:  return store_cyc - 1;
      XF_RECALL: return recall_cyc - 1;
      default:   return 0;
    endcase
  endfunction

  // true while the step counter still points at a real word
  function automatic logic in_walk(int unsigned step, int unsigned depth);
    return step < depth;
  endfunction

endpackage

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned STORE_CYCLES  = 320,
  parameter int unsigned RECALL_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic              restore_req,
  output xfer_e             mode,
  output logic              busy,
  output logic              step_valid,
  output logic [ADDR_W-1:0] step_addr,
  output logic              start_store,
  output logic              start_recall
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned MAXD  = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int unsigned CW    = $clog2(MAXD + 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign busy         = (mode != XF_IDLE);
  assign start_recall = !busy && restore_req;
  assign start_store  = !busy && save_req && !restore_req;
  assign last         = (32'(cnt) == span_last(mode, STORE_CYCLES, RECALL_CYCLES));
  assign step_valid   = busy && in_walk(32'(cnt), DEPTH);
  assign step_addr    = cnt[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= XF_IDLE;
      cnt  <= '0;
    end else if (!busy) begin
      cnt <= '0;
      if (start_recall)     mode <= XF_RECALL;
      else if (start_store) mode <= XF_STORE;
    end else if (last) begin
      mode <= XF_IDLE;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: an accepted save enters the store transfer on the next edge
  p_save_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_store |=> (mode == XF_STORE));

  // R8: restore low on an idle cycle always yields a recall
  p_recall_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && restore_req) |=> (mode == XF_RECALL));

  // R6: a running store is not diverted before its final cycle
  p_store_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XF_STORE && !last) |=> (mode == XF_STORE));

  // R7: the walk advances one step per cycle
  p_walk_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/nvs_access.sv
module nvs_access (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic wr_n,
  input  logic busy,
  input  logic start_any,
  input  logic start_store,
  output logic host_we,
  output logic read_en,
  output logic poison_we
);
  logic open_slot;

  assign open_slot = !busy && !start_any && !sel_n;
  assign host_we   = open_slot && !wr_n;
  assign read_en   = open_slot && wr_n;
  // a save that starts on top of a host write cuts the write off
  assign poison_we = start_store && !sel_n && !wr_n;

  // R3: a cut-off write is never also committed
  p_abort_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poison_we |-> !host_we);

  // R4: deselect keeps both paths shut
  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!read_en && !host_we));

endmodule

// File: rtl/nvs_storage.sv
module nvs_storage #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              poison_we,
  input  logic              copy_to_nv,
  input  logic              copy_to_ram,
  input  logic [ADDR_W-1:0] copy_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bad
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram    [DEPTH];
  logic              ram_bad[DEPTH];
  logic [DATA_W-1:0] nv     [DEPTH];
  logic              nv_bad [DEPTH];

  assign rd_data = ram[host_addr];
  assign rd_bad  = ram_bad[host_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ram[i]     <= '0;
        ram_bad[i] <= 1'b0;
      end
    end else if (copy_to_ram) begin
      ram[copy_addr]     <= nv[copy_addr];
      ram_bad[copy_addr] <= nv_bad[copy_addr];
    end else if (host_we) begin
      ram[host_addr]     <= host_data;
      ram_bad[host_addr] <= 1'b0;
    end else if (poison_we) begin
      ram_bad[host_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        nv[i]     <= '0;
        nv_bad[i] <= 1'b0;
      end
    end else if (copy_to_nv) begin
      nv[copy_addr]     <= ram[copy_addr];
      nv_bad[copy_addr] <= ram_bad[copy_addr];
    end
  end

  // R11: a transfer step and a host write never compete for the RAM
  p_one_writer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_to_ram || copy_to_nv) |-> !host_we);

endmodule

// File: rtl/nvsram_shadow.sv
module nvsram_shadow
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned STORE_CYCLES  = 320,
  parameter int unsigned RECALL_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rd_bad,
  input  logic              save_n,
  input  logic              restore_n,
  output logic              busy
);
  xfer_e             mode;
  logic              step_valid;
  logic [ADDR_W-1:0] step_addr;
  logic              start_store, start_recall;
  logic              host_we, read_en, poison_we;
  logic              copy_to_nv, copy_to_ram;
  logic [DATA_W-1:0] word;
  logic              word_bad;

  nvs_sequencer #(
    .ADDR_W(ADDR_W), .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .save_req(!save_n), .restore_req(!restore_n),
    .mode(mode), .busy(busy), .step_valid(step_valid), .step_addr(step_addr),
    .start_store(start_store), .start_recall(start_recall)
  );

  nvs_access u_acc (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .busy(busy),
    .start_any(start_store || start_recall), .start_store(start_store),
    .host_we(host_we), .read_en(read_en), .poison_we(poison_we)
  );

  assign copy_to_nv  = step_valid && (mode == XF_STORE);
  assign copy_to_ram = step_valid && (mode == XF_RECALL);

  nvs_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(addr), .host_data(din), .poison_we(poison_we),
    .copy_to_nv(copy_to_nv), .copy_to_ram(copy_to_ram), .copy_addr(step_addr),
    .rd_data(word), .rd_bad(word_bad)
  );

  assign dout_en = read_en;
  assign dout    = read_en ? word : '0;
  assign rd_bad  = read_en && word_bad;

  // R4: pads stay released for the whole transfer
  p_pads_off_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);

  // R10: an arriving command releases the pads at once
  p_cmd_drops_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_n || !restore_n) |-> !dout_en);

endmodule

// File: tb/nvsram_shadow_bench.sv
module nvsram_shadow_bench;
  localparam int CLK_NS     = 10;
  localparam int STORE_CYC  = 320;
  localparam int RECALL_CYC = 256;
  localparam int DEPTH      = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, wr_n = 1'b1, save_n = 1'b1, restore_n = 1'b1;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_en, rd_bad, busy;

  int checks = 0, fails = 0, cycles = 0;
  logic [3:0] m_ram[DEPTH];
  logic       m_bad[DEPTH];
  logic [3:0] m_nv[DEPTH];
  logic       m_nvbad[DEPTH];

  nvsram_shadow #(.STORE_CYCLES(STORE_CYC), .RECALL_CYCLES(RECALL_CYC)) u_nvsram_shadow (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .rd_bad(rd_bad), .save_n(save_n),
    .restore_n(restore_n), .busy(busy));

  always #(CLK_NS/2) clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int a, input int salt);
    return 4'((a ^ (a >> 4) ^ salt) & 15);
  endfunction

  task automatic host_write(input int a, input int d);
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b0; addr = 8'(a); din = 4'(d);
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b1;
    m_ram[a] = 4'(d); m_bad[a] = 1'b0;
  endtask

  task automatic read_one(input int a, input string tag);
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b1; addr = 8'(a);
    #1;
    chk({tag, " dout_en"}, int'(dout_en), 1);
    chk({tag, " data"}, int'(dout), int'(m_ram[a]));
    chk({tag, " bad"}, int'(rd_bad), int'(m_bad[a]));
    sel_n = 1'b1;
  endtask

  task automatic verify_all(input string tag);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); sel_n = 1'b0; wr_n = 1'b1; addr = 8'(a);
      #1;
      if (!dout_en || rd_bad != m_bad[a] || (!m_bad[a] && dout != m_ram[a])) bad++;
    end
    sel_n = 1'b1;
    chk({tag, " word mismatches"}, bad, 0);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk); #1;
      if (!busy) break;
      n++;
    end
  endtask

  task automatic model_store();
    for (int a = 0; a < DEPTH; a++) begin m_nv[a] = m_ram[a]; m_nvbad[a] = m_bad[a]; end
  endtask

  task automatic model_recall();
    for (int a = 0; a < DEPTH; a++) begin m_ram[a] = m_nv[a]; m_bad[a] = m_nvbad[a]; end
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 dout_en idle", int'(dout_en), 0);
    for (int a = 0; a < DEPTH; a++) begin
      m_ram[a] = '0; m_bad[a] = 0; m_nv[a] = '0; m_nvbad[a] = 0;
    end
    verify_all("R1 reset contents");
  endtask

  task automatic t_rw();
    host_write(0, 9); host_write(255, 6); host_write(8'h5A, 15);
    read_one(0, "R2 addr0"); read_one(255, "R2 addr255"); read_one(8'h5A, "R2 addr5A");
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b0; addr = 8'h11; din = 4'd12;
    #1 chk("R3 dout_en during write", int'(dout_en), 0);
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b1; m_ram[8'h11] = 4'd12;
    #1 chk("R4 dout_en deselected", int'(dout_en), 0);
    read_one(8'h11, "R3 write landed");
  endtask

  task automatic t_store_noisy();
    int n = 0;
    for (int a = 0; a < DEPTH; a++) host_write(a, pat(a, 0));
    @(negedge clk); save_n = 1'b0;
    @(posedge clk); #1 save_n = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (k == 3) begin
        sel_n = 1'b0; wr_n = 1'b0; addr = 8'd3; din = ~pat(3, 0);
        restore_n = 1'b0; save_n = 1'b0;
        #1 chk("R4 dout_en while busy", int'(dout_en), 0);
      end
      if (k == 6) begin sel_n = 1'b1; wr_n = 1'b1; restore_n = 1'b1; save_n = 1'b1; end
      #1;
      if (!busy) break;
      n++;
    end
    chk("R5 R6 store length", n, STORE_CYC);
    model_store();
    read_one(3, "R6 R11 write ignored during store");
  endtask

  task automatic t_recall();
    int n;
    for (int a = 0; a < DEPTH; a++) host_write(a, pat(a, 5));
    @(negedge clk); restore_n = 1'b0;
    @(posedge clk); #1 restore_n = 1'b1;
    count_busy(n);
    chk("R7 recall length", n, RECALL_CYC);
    model_recall();
    verify_all("R7 recall contents");
  endtask

  task automatic t_both_low();
    int n;
    host_write(7, ~pat(7, 0));
    @(negedge clk); save_n = 1'b0; restore_n = 1'b0;
    @(posedge clk); #1 save_n = 1'b1; restore_n = 1'b1;
    count_busy(n);
    chk("R8 both low gives recall length", n, RECALL_CYC);
    model_recall();
    read_one(7, "R8 word7 restored");
  endtask

  task automatic t_read_then_store();
    int n;
    host_write(20, 4'd1);
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b1; addr = 8'd5;
    #1 chk("R10 read before command", int'(dout_en), 1);
    save_n = 1'b0;
    #1 chk("R10 command drops read", int'(dout_en), 0);
    @(posedge clk); #1 save_n = 1'b1; sel_n = 1'b1;
    count_busy(n);
    chk("R5 store length", n, STORE_CYC);
    model_store();
  endtask

  task automatic t_abort_write();
    int n;
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b0; addr = 8'd9; din = 4'd5; save_n = 1'b0;
    @(posedge clk); #1 sel_n = 1'b1; wr_n = 1'b1; save_n = 1'b1;
    count_busy(n);
    chk("R9 store after abort length", n, STORE_CYC);
    m_bad[9] = 1'b1;
    model_store();
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b1; addr = 8'd9;
    #1 chk("R9 aborted word flagged", int'(rd_bad), 1);
    sel_n = 1'b1;
    host_write(9, 3);
    read_one(9, "R9 rewrite clears flag");
    @(negedge clk); restore_n = 1'b0;
    @(posedge clk); #1 restore_n = 1'b1;
    count_busy(n);
    model_recall();
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b1; addr = 8'd9;
    #1 chk("R9 flag returns with recall", int'(rd_bad), 1);
    sel_n = 1'b1;
    verify_all("R9 R7 array after recall");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_rw();
    t_store_noisy();
    t_recall();
    t_both_low();
    t_read_then_store();
    t_abort_write();
    finish_run();
  end
endmodule